// File: doc/BRIEF.md
# Synchronous Burst SRAM Cycle Controller

This block is the clocked front end of a small on-chip static memory that is accessed in short bursts. On every rising clock edge it looks at three chip selects, two start strobes (a processor-side strobe and a controller-side strobe), a step input, a global write enable, a byte-write enable and one enable per byte lane. From these it decides which kind of cycle the edge starts: a deselect, the start of a read or write burst, a step to the next burst address, or a hold on the current address. Writes go into the array one byte lane at a time under a mask. Reads come back either one clock late through an output register or in the same cycle straight from the array. A static input picks between the two.

The burst address is made from a start address captured at the start of the burst and a small beat counter. A static input sets the beat order: interleaved (the low address bits XOR the count) or linear (the low address bits plus the count, wrapping inside the burst). The data output comes with an enable for a tristate driver. That enable follows an asynchronous output-enable input, and it is forced off in any cycle that writes.

Top module: `bsram_core`

## Requirements
- R1: A strobe edge starts a burst only when `cs_master_n`=0, `cs_hi`=1 and `cs_lo_n`=0. If a strobe edge sees `cs_hi`=0 or `cs_lo_n`=1, that edge is a deselect: nothing is written and the block goes idle.
- R2: When `cs_master_n`=1 the processor strobe is blocked. With `strb_ctl_n`=1, such an edge acts as a step or hold cycle of the running burst. With `strb_ctl_n`=0, it is a deselect.
- R3: A burst started by the processor strobe (`strb_cpu_n`=0, `cs_master_n`=0) is always a read. `wr_all_n`, `wr_byte_n` and `byte_en_n` are ignored on that edge.
- R4: A burst started by the controller strobe (processor strobe high or blocked) samples the write enables on that same edge. `wr_all_n`=0 writes every lane. Otherwise lane i (data bits [8i+7:8i]) is written only when `wr_byte_n`=0 and `byte_en_n[i]`=0. When no lane is selected, the cycle is a read.
- R5: With both strobes inactive, the chip selects are ignored. `step_n`=0 moves to the next beat and `step_n`=1 holds the current address. The beat address keeps the upper bits of the start address. Its low two bits are start XOR count when `linear`=0, and start plus count modulo 4 when `linear`=1.
- R6: With `flow_thru`=0, read data for an address registered on edge k appears on `dout` after edge k+1.
- R7: With `flow_thru`=1, read data for an address registered on edge k appears on `dout` after edge k itself.
- R8: `dout_en` is 1 only when `out_en_n`=0 and the current cycle is a read. `out_en_n` acts without waiting for a clock edge, and `dout_en` is 0 during and after reset.
- R9: In a cycle whose edge qualified a write, `dout_en` is 0 whatever `out_en_n` is.
- R10: After a deselect edge k, `dout_en` is 0 from edge k+1 on in pipelined mode, and from edge k on in flow-through mode.
- R11: Write data is captured on the edge that qualifies the write and is committed to the array under the lane mask. A read of that address started on the very next edge returns the new data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | ADDR_W | Start address, used on a burst start |
| cs_master_n | input | 1 | Master chip select, active low; blocks the processor strobe |
| cs_hi | input | 1 | Secondary chip select, active high |
| cs_lo_n | input | 1 | Secondary chip select, active low |
| strb_cpu_n | input | 1 | Processor start strobe, active low |
| strb_ctl_n | input | 1 | Controller start strobe, active low |
| step_n | input | 1 | Burst step, active low |
| wr_all_n | input | 1 | Global write, active low |
| wr_byte_n | input | 1 | Byte-write qualifier, active low |
| byte_en_n | input | NBYTE | Per-lane write enables, active low |
| out_en_n | input | 1 | Asynchronous output enable, active low |
| linear | input | 1 | Static beat order: 1 linear, 0 interleaved |
| flow_thru | input | 1 | Static read path: 1 flow-through, 0 pipelined |
| din | input | NBYTE*BYTE_W | Write data |
| dout | output | NBYTE*BYTE_W | Read data |
| dout_en | output | 1 | Drive enable for the data pins |

## Verification
The bench builds the block with ADDR_W=6, NBYTE=2, BYTE_W=8 and BURST_W=2. That gives a 64-word array of two lanes, small enough that a few bursts fill every word before any read depends on it. Two lanes are enough to show one lane being written while its neighbour keeps its old value. A four-beat burst makes the interleaved and linear orders differ on start offset 1, so one address pattern tells them apart. Both output paths run against the same memory contents, so the one-cycle difference in latency and in release after a deselect is seen directly.

// File: rtl/bsram_pkg.sv
package bsram_pkg;
   // Kind of cycle decoded on one clock edge
   typedef enum logic [1:0] {
      K_DESEL = 2'd0,
      K_START = 2'd1,
      K_NEXT  = 2'd2,
      K_HOLD  = 2'd3
   } kind_e;
endpackage

// File: rtl/bsram_decode.sv
module bsram_decode
   import bsram_pkg::*;
#(
   parameter int NBYTE = 2
) (
   input  logic             cs_master_n,
   input  logic             cs_hi,
   input  logic             cs_lo_n,
   input  logic             strb_cpu_n,
   input  logic             strb_ctl_n,
   input  logic             step_n,
   input  logic             wr_all_n,
   input  logic             wr_byte_n,
   input  logic [NBYTE-1:0] byte_en_n,
   output kind_e            kind,
   output logic [NBYTE-1:0] mask
);
   logic cpu_go, ctl_go, sel_ok;

   always_comb begin
      // the master select gates only the processor strobe
      cpu_go = !strb_cpu_n && !cs_master_n;
      ctl_go = !cpu_go && !strb_ctl_n;
      sel_ok = !cs_master_n && cs_hi && !cs_lo_n;
      if (cpu_go || ctl_go)
         kind = sel_ok ? K_START : K_DESEL;
      else
         kind = step_n ? K_HOLD : K_NEXT;
      if (cpu_go)
         mask = '0;
      else if (!wr_all_n)
         mask = '1;
      else if (!wr_byte_n)
         mask = ~byte_en_n;
      else
         mask = '0;
   end
endmodule

// File: rtl/bsram_burst.sv
module bsram_burst #(
   parameter int ADDR_W  = 6,
   parameter int BURST_W = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic              step,
   input  logic [ADDR_W-1:0] load_addr,
   input  logic              linear,
   output logic [ADDR_W-1:0] cur_addr,
   output logic [ADDR_W-1:0] nxt_addr
);
   logic [ADDR_W-1:0]  base_q;
   logic [BURST_W-1:0] cnt_q;

   function automatic logic [ADDR_W-1:0] form(input logic [ADDR_W-1:0] b,
                                              input logic [BURST_W-1:0] c,
                                              input logic lin);
      logic [BURST_W-1:0] lo;
      lo = lin ? (b[BURST_W-1:0] + c) : (b[BURST_W-1:0] ^ c);
      return {b[ADDR_W-1:BURST_W], lo};
   endfunction

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         base_q <= '0;
         cnt_q  <= '0;
      end else if (load) begin
         base_q <= load_addr;
         cnt_q  <= '0;
      end else if (step) begin
         cnt_q  <= cnt_q + 1'b1;
      end
   end

   always_comb begin
      cur_addr = form(base_q, cnt_q, linear);
      if (load)
         nxt_addr = load_addr;
      else if (step)
         nxt_addr = form(base_q, cnt_q + 1'b1, linear);
      else
         nxt_addr = cur_addr;
   end
endmodule

// File: rtl/bsram_lanes.sv
module bsram_lanes #(
   parameter int ADDR_W = 6,
   parameter int NBYTE  = 2,
   parameter int BYTE_W = 8
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic [NBYTE-1:0]        cap_mask,
   input  logic [ADDR_W-1:0]       cap_addr,
   input  logic [NBYTE*BYTE_W-1:0] cap_data,
   input  logic [ADDR_W-1:0]       rd_addr,
   output logic [NBYTE*BYTE_W-1:0] rd_data
);
   localparam int DEPTH = 1 << ADDR_W;
   localparam int DW    = NBYTE * BYTE_W;

   // input register: holds a qualified write for one cycle
   logic [NBYTE-1:0]  mask_q;
   logic [ADDR_W-1:0] addr_q;
   logic [DW-1:0]     data_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mask_q <= '0;
         addr_q <= '0;
         data_q <= '0;
      end else begin
         mask_q <= cap_mask;
         addr_q <= cap_addr;
         data_q <= cap_data;
      end
   end

   for (genvar g = 0; g < NBYTE; g++) begin : g_lane
      logic [BYTE_W-1:0] mem [DEPTH];
      always_ff @(posedge clk) begin
         if (mask_q[g])
            mem[addr_q] <= data_q[g*BYTE_W +: BYTE_W];
      end
      assign rd_data[g*BYTE_W +: BYTE_W] = mem[rd_addr];
   end
endmodule

// File: rtl/bsram_core.sv
module bsram_core
   import bsram_pkg::*;
#(
   parameter int ADDR_W  = 6,
   parameter int NBYTE   = 2,
   parameter int BYTE_W  = 8,
   parameter int BURST_W = 2
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic [ADDR_W-1:0]       addr,
   input  logic                    cs_master_n,
   input  logic                    cs_hi,
   input  logic                    cs_lo_n,
   input  logic                    strb_cpu_n,
   input  logic                    strb_ctl_n,
   input  logic                    step_n,
   input  logic                    wr_all_n,
   input  logic                    wr_byte_n,
   input  logic [NBYTE-1:0]        byte_en_n,
   input  logic                    out_en_n,
   input  logic                    linear,
   input  logic                    flow_thru,
   input  logic [NBYTE*BYTE_W-1:0] din,
   output logic [NBYTE*BYTE_W-1:0] dout,
   output logic                    dout_en
);
   localparam int DW = NBYTE * BYTE_W;

   initial begin
      assert (NBYTE >= 1) else $error("NBYTE must be at least 1");
      assert (BYTE_W >= 1) else $error("BYTE_W must be at least 1");
      assert (BURST_W >= 1 && BURST_W < ADDR_W) else $error("BURST_W out of range");
      assert (ADDR_W <= 12) else $error("ADDR_W too large for an on-chip array");
   end

   kind_e             kind;
   logic [NBYTE-1:0]  mask, cap_mask;
   logic [ADDR_W-1:0] cur_addr, nxt_addr;
   logic [DW-1:0]     rd_data, pipe_data;
   logic              act, rd_now, wr_now, pipe_vld;
   logic              seq_cyc, do_load, do_step, wr_cyc;

   bsram_decode #(.NBYTE(NBYTE)) u_dec (
      .cs_master_n(cs_master_n), .cs_hi(cs_hi), .cs_lo_n(cs_lo_n),
      .strb_cpu_n(strb_cpu_n), .strb_ctl_n(strb_ctl_n), .step_n(step_n),
      .wr_all_n(wr_all_n), .wr_byte_n(wr_byte_n), .byte_en_n(byte_en_n),
      .kind(kind), .mask(mask)
   );

   always_comb begin
      seq_cyc  = act && (kind == K_NEXT || kind == K_HOLD);
      do_load  = (kind == K_START);
      do_step  = act && (kind == K_NEXT);
      cap_mask = (do_load || seq_cyc) ? mask : '0;
      wr_cyc   = |cap_mask;
   end

   bsram_burst #(.ADDR_W(ADDR_W), .BURST_W(BURST_W)) u_burst (
      .clk(clk), .rst_n(rst_n), .load(do_load), .step(do_step),
      .load_addr(addr), .linear(linear),
      .cur_addr(cur_addr), .nxt_addr(nxt_addr)
   );

   bsram_lanes #(.ADDR_W(ADDR_W), .NBYTE(NBYTE), .BYTE_W(BYTE_W)) u_lanes (
      .clk(clk), .rst_n(rst_n), .cap_mask(cap_mask), .cap_addr(nxt_addr),
      .cap_data(din), .rd_addr(cur_addr), .rd_data(rd_data)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         act       <= 1'b0;
         rd_now    <= 1'b0;
         wr_now    <= 1'b0;
         pipe_vld  <= 1'b0;
         pipe_data <= '0;
      end else begin
         unique case (kind)
            K_DESEL: begin
               act    <= 1'b0;
               rd_now <= 1'b0;
               wr_now <= 1'b0;
            end
            K_START: begin
               act    <= 1'b1;
               rd_now <= !wr_cyc;
               wr_now <= wr_cyc;
            end
            default: begin
               rd_now <= seq_cyc && !wr_cyc;
               wr_now <= wr_cyc;
            end
         endcase
         pipe_vld  <= rd_now;
         pipe_data <= rd_data;
      end
   end

   always_comb begin
      dout    = flow_thru ? rd_data : pipe_data;
      dout_en = (flow_thru ? rd_now : pipe_vld) && !out_en_n && !wr_now;
   end
endmodule

// File: rtl/bsram_core_chk.sv
module bsram_core_chk #(
   parameter int NBYTE = 2
) (
   input logic             clk,
   input logic             rst_n,
   input logic             cs_master_n,
   input logic             cs_hi,
   input logic             cs_lo_n,
   input logic             strb_cpu_n,
   input logic             strb_ctl_n,
   input logic             wr_all_n,
   input logic             wr_byte_n,
   input logic [NBYTE-1:0] byte_en_n,
   input logic             out_en_n,
   input logic             flow_thru,
   input logic             dout_en
);
   logic sel_ok, cpu_go, ctl_go, any_go;
   assign sel_ok = !cs_master_n && cs_hi && !cs_lo_n;
   assign cpu_go = !strb_cpu_n && !cs_master_n;
   assign ctl_go = !cpu_go && !strb_ctl_n;
   assign any_go = cpu_go || ctl_go;

   // R10 pipelined: output released one edge after the deselect edge
   p_desel_pipe_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (any_go && !sel_ok && !flow_thru) |=> ##1 (!dout_en || flow_thru));

   // R10 flow-through: output released on the deselect edge
   p_desel_flow_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (any_go && !sel_ok && flow_thru) |=> (!dout_en || !flow_thru));

   // R9: a global write start mutes the output
   p_wr_mute_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl_go && sel_ok && !wr_all_n) |=> !dout_en);

   // R8: output enable high keeps the pins undriven
   p_oe_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
      out_en_n |-> !dout_en);

   // R3: a processor-strobe start is a read even with writes asserted
   p_cpu_read_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_go && sel_ok && flow_thru && !out_en_n)
      |=> (dout_en || out_en_n || !flow_thru));

   // R4: a controller start with no lane selected is a read
   p_nolane_read_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl_go && sel_ok && wr_all_n && (wr_byte_n || (&byte_en_n)) && flow_thru && !out_en_n)
      |=> (dout_en || out_en_n || !flow_thru));
endmodule

bind bsram_core bsram_core_chk #(.NBYTE(NBYTE)) u_chk (
   .clk(clk), .rst_n(rst_n), .cs_master_n(cs_master_n), .cs_hi(cs_hi),
   .cs_lo_n(cs_lo_n), .strb_cpu_n(strb_cpu_n), .strb_ctl_n(strb_ctl_n),
   .wr_all_n(wr_all_n), .wr_byte_n(wr_byte_n), .byte_en_n(byte_en_n),
   .out_en_n(out_en_n), .flow_thru(flow_thru), .dout_en(dout_en)
);

// File: tb/bsram_core_test.sv
`timescale 1ns/1ps
module bsram_core_test;
   localparam int AW = 6;
   localparam int NB = 2;
   localparam int BW = 8;
   localparam int DW = NB * BW;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [AW-1:0] addr = '0;
   logic          m_n = 1'b0, hi = 1'b1, lo_n = 1'b0;
   logic          cpu_n = 1'b1, ctl_n = 1'b1, step_n = 1'b1;
   logic          gall_n = 1'b1, bbyte_n = 1'b1;
   logic [NB-1:0] ben_n = '1;
   logic          oe_n = 1'b0, lin = 1'b0, flow = 1'b0;
   logic [DW-1:0] din = '0;
   logic [DW-1:0] dout;
   logic          dout_en;

   logic [DW-1:0] model [1 << AW];
   int total = 0;
   int bad = 0;
   int cycles = 0;

   always #4 clk = ~clk;

   bsram_core #(.ADDR_W(AW), .NBYTE(NB), .BYTE_W(BW), .BURST_W(2)) uut (
      .clk(clk), .rst_n(rst_n), .addr(addr), .cs_master_n(m_n), .cs_hi(hi),
      .cs_lo_n(lo_n), .strb_cpu_n(cpu_n), .strb_ctl_n(ctl_n), .step_n(step_n),
      .wr_all_n(gall_n), .wr_byte_n(bbyte_n), .byte_en_n(ben_n),
      .out_en_n(oe_n), .linear(lin), .flow_thru(flow), .din(din),
      .dout(dout), .dout_en(dout_en)
   );

   always @(posedge clk) begin
      cycles++;
      if (cycles > 20000) begin
         bad++;
         total++;
         $display("FAIL watchdog: act=%0d exp<=%0d cycles", cycles, 20000);
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s act=%h exp=%h", tag, act, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      @(negedge clk);
   endtask

   // one clock: cpu/ctl assert strobes, stp steps, ga global write, bb byte write, be lanes
   task automatic go(input bit cpu, input bit ctl, input logic [AW-1:0] a, input bit stp,
                     input bit ga, input bit bb, input logic [NB-1:0] be, input logic [DW-1:0] d);
      cpu_n = !cpu; ctl_n = !ctl; addr = a; step_n = !stp;
      gall_n = !ga; bbyte_n = !bb; ben_n = ~be; din = d;
      tick();
   endtask

   task automatic idle();
      go(0, 0, '0, 0, 0, 0, '0, '0);
   endtask

   function automatic logic [AW-1:0] baddr(input logic [AW-1:0] s, input int i, input bit l);
      logic [1:0] lo;
      lo = l ? (s[1:0] + 2'(i)) : (s[1:0] ^ 2'(i));
      return {s[AW-1:2], lo};
   endfunction

   // R4/R5/R9/R11: global-write burst from the controller strobe
   task automatic t_wr_burst(input logic [AW-1:0] s, input int n, input bit l, input logic [DW-1:0] seed);
      lin = l;
      go(0, 1, s, 0, 1, 0, '0, seed);
      model[s] = seed;
      chk("R9 write mutes output", dout_en, 0);
      for (int i = 1; i < n; i++) begin
         go(0, 0, '0, 1, 1, 0, '0, seed + DW'(i * 16'h1111));
         model[baddr(s, i, l)] = seed + DW'(i * 16'h1111);
      end
      idle();
   endtask

   // R5/R6/R7: read burst, checked beat by beat
   task automatic t_rd_burst(input logic [AW-1:0] s, input int n, input bit cpu, input bit l, input string tag);
      lin = l;
      go(cpu, !cpu, s, 0, 0, 0, '0, '0);
      if (flow) begin
         chk({tag, " en"}, dout_en, 1);
         chk(tag, dout, model[s]);
         for (int i = 1; i < n; i++) begin
            go(0, 0, '0, 1, 0, 0, '0, '0);
            chk(tag, dout, model[baddr(s, i, l)]);
         end
      end else begin
         for (int i = 1; i < n; i++) begin
            go(0, 0, '0, 1, 0, 0, '0, '0);
            chk({tag, " en"}, dout_en, 1);
            chk(tag, dout, model[baddr(s, i - 1, l)]);
         end
         idle();
         chk(tag, dout, model[baddr(s, n - 1, l)]);
      end
   endtask

   task automatic t_fill();
      flow = 1'b0;
      for (int b = 0; b < (1 << AW) / 4; b++)
         t_wr_burst(AW'(b * 4), 4, 1, DW'(16'h5000 ^ (b * 16'h0307)));
   endtask

   task automatic t_orders();
      flow = 1'b0;
      t_rd_burst(6'd49, 4, 1, 0, "R6 R5 interleaved pipelined");
      t_rd_burst(6'd49, 4, 1, 1, "R6 R5 linear pipelined");
      flow = 1'b1;
      t_rd_burst(6'd49, 4, 0, 0, "R7 R5 interleaved flow");
      t_rd_burst(6'd49, 4, 0, 1, "R7 R5 linear flow");
      t_wr_burst(6'd17, 4, 0, 16'h0A0B);
      t_rd_burst(6'd17, 4, 1, 0, "R5 interleaved write order");
   endtask

   task automatic t_suspend();
      flow = 1'b1; lin = 1'b0;
      go(1, 0, 6'd5, 0, 0, 0, '0, '0);
      chk("R5 start", dout, model[5]);
      go(0, 0, '0, 0, 0, 0, '0, '0);
      chk("R5 hold keeps address", dout, model[5]);
      go(0, 0, '0, 1, 0, 0, '0, '0);
      chk("R5 step", dout, model[4]);
      go(0, 0, '0, 0, 0, 0, '0, '0);
      chk("R5 hold again", dout, model[4]);
      go(0, 0, '0, 1, 0, 0, '0, '0);
      chk("R5 step again", dout, model[7]);
   endtask

   task automatic t_bytes();
      flow = 1'b1;
      go(0, 1, 6'd12, 0, 0, 1, 2'b01, 16'hBEEF);
      model[12] = {model[12][15:8], 8'hEF};
      go(0, 1, 6'd13, 0, 0, 1, 2'b10, 16'hC3A5);
      model[13] = {8'hC3, model[13][7:0]};
      go(0, 1, 6'd14, 0, 0, 1, 2'b00, 16'hFFFF);
      chk("R4 no lane is read en", dout_en, 1);
      chk("R4 no lane is read", dout, model[14]);
      go(0, 1, 6'd15, 0, 0, 0, 2'b01, 16'hFFFF);
      chk("R4 lane without byte-write is read", dout_en, 1);
      go(1, 0, 6'd12, 0, 0, 0, '0, '0);
      chk("R4 lane 0 only", dout, model[12]);
      go(1, 0, 6'd13, 0, 0, 0, '0, '0);
      chk("R4 lane 1 only", dout, model[13]);
      go(1, 0, 6'd15, 0, 0, 0, '0, '0);
      chk("R4 unqualified lane kept", dout, model[15]);
   endtask

   task automatic t_cpu_read();
      flow = 1'b1;
      go(1, 0, 6'd20, 0, 1, 0, '0, 16'h0000);
      chk("R3 cpu start reads en", dout_en, 1);
      chk("R3 cpu start reads", dout, model[20]);
      idle();
      chk("R3 global ignored", dout, model[20]);
      go(1, 0, 6'd21, 0, 0, 1, 2'b11, 16'h0000);
      idle();
      chk("R3 lanes ignored", dout, model[21]);
   endtask

   task automatic t_select();
      flow = 1'b1;
      go(1, 0, 6'd22, 0, 0, 0, '0, '0);
      chk("R1 read before", dout, model[22]);
      hi = 1'b0;
      go(0, 1, 6'd23, 0, 1, 0, '0, 16'h0000);
      chk("R1 R10 deselect flow", dout_en, 0);
      hi = 1'b1;
      idle();
      chk("R1 idle after deselect", dout_en, 0);
      lo_n = 1'b1;
      go(1, 0, 6'd22, 0, 0, 0, '0, '0);
      chk("R1 low select inactive", dout_en, 0);
      lo_n = 1'b0;
      go(1, 0, 6'd23, 0, 0, 0, '0, '0);
      chk("R1 no write on deselect", dout, model[23]);
   endtask

   task automatic t_master();
      flow = 1'b1; lin = 1'b1;
      go(1, 0, 6'd24, 0, 0, 0, '0, '0);
      m_n = 1'b1;
      go(1, 0, 6'd40, 1, 0, 0, '0, '0);
      chk("R2 blocked strobe steps en", dout_en, 1);
      chk("R2 blocked strobe steps", dout, model[25]);
      go(1, 1, 6'd40, 0, 0, 0, '0, '0);
      chk("R2 ctl strobe with master high", dout_en, 0);
      m_n = 1'b0;
      go(1, 0, 6'd28, 0, 0, 0, '0, '0);
      hi = 1'b0;
      go(0, 0, '0, 1, 0, 0, '0, '0);
      chk("R5 selects ignored on step", dout, model[29]);
      hi = 1'b1;
   endtask

   task automatic t_oe();
      flow = 1'b1;
      go(1, 0, 6'd30, 0, 0, 0, '0, '0);
      chk("R8 enabled", dout_en, 1);
      oe_n = 1'b1;
      #1;
      chk("R8 async off", dout_en, 0);
      oe_n = 1'b0;
      #1;
      chk("R8 async on", dout_en, 1);
   endtask

   task automatic t_desel_pipe();
      flow = 1'b0; lin = 1'b1;
      go(1, 0, 6'd32, 0, 0, 0, '0, '0);
      go(0, 0, '0, 1, 0, 0, '0, '0);
      chk("R6 first beat", dout, model[32]);
      m_n = 1'b1;
      go(0, 1, 6'd0, 0, 0, 0, '0, '0);
      m_n = 1'b0;
      chk("R10 pipe still driving", dout_en, 1);
      chk("R10 pipe last data", dout, model[33]);
      idle();
      chk("R10 pipe released", dout_en, 0);
   endtask

   task automatic t_wr_then_rd();
      flow = 1'b0;
      go(0, 1, 6'd40, 0, 1, 0, '0, 16'h7E57);
      model[40] = 16'h7E57;
      go(1, 0, 6'd40, 0, 0, 0, '0, '0);
      idle();
      chk("R11 pipelined read after write", dout, 16'h7E57);
      flow = 1'b1;
      go(0, 1, 6'd41, 0, 1, 0, '0, 16'h1D1E);
      model[41] = 16'h1D1E;
      go(1, 0, 6'd41, 0, 0, 0, '0, '0);
      chk("R11 flow read after write", dout, 16'h1D1E);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      chk("R8 reset state", dout_en, 0);
      rst_n = 1'b1;
      @(negedge clk);
      t_fill();
      t_orders();
      t_suspend();
      t_bytes();
      t_cpu_read();
      t_select();
      t_master();
      t_oe();
      t_desel_pipe();
      t_wr_then_rd();
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule